// File: doc/BRIEF.md
# Edge-Aligned PWM Channel

This block produces one pulse-width-modulated output from a 16-bit up-counting timebase. A programmable clock divider sets how often the timebase advances. The timebase climbs from zero to a programmable period limit and then drops back to zero, so the count has a single slope. A compare threshold decides where in each period the output changes level. A polarity input chooses between the normal waveform and its complement. Every period begins at the same edge, so the waveform is left-aligned.

Software writes the period limit and the compare threshold into holding registers at any time. The timebase copies both into its working registers only when it drops from the limit back to zero. A change therefore never cuts a period short and never produces a runt pulse. A one-clock strobe marks each restart of the period. An enable input freezes the divider, the timebase and the output level while it is low.

Top module: `pwm_edge_gen`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first enabled clock, the divider, the timebase, both register stages and `wrap_pulse` are zero. `pwm_out` is 0 when `invert`=0 and 1 when `invert`=1.
- R2: The divider counts enabled clocks. When its count is at or above `pre_div`, it issues one timebase tick and returns to 0, which gives one tick per `pre_div`+1 enabled clocks. While `en` is low, the divider, the timebase and the output level hold their values and `wrap_pulse` is 0.
- R3: On each tick the timebase adds one. A tick that finds the count at or above the working period limit sets the count to 0 instead. This is a wrap, and `wrap_pulse` is 1 for exactly the clock that follows it.
- R4: With constant settings, consecutive `wrap_pulse` assertions are (limit+1)*(`pre_div`+1) clocks apart.
- R5: For a threshold C with 0 < C < limit, the normal output level is 1 when the count is at or above C and 0 when it is below C. The output is set at the compare match and cleared at zero. `pwm_out` shows the level of the count present one clock earlier.
- R6: With `invert`=1, `pwm_out` is the complement of the normal level. The polarity input acts without delay.
- R7: A write with `top_wr` or `cmp_wr` loads only the holding register. The working limit and working threshold copy the holding registers only at a wrap. A write in the same clock as a wrap takes effect at the following wrap.
- R8: A working threshold at or above the working limit, and not zero, keeps the normal level at 0.
- R9: A working threshold of 0 keeps the normal level at 1. This rule wins over R8 when the limit is also 0.
- R10: For 0 < C < limit, the normal output is high for (limit−C+1)*(`pre_div`+1) clocks of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low freezes the channel |
| pre_div | input | 8 | Divider setting; one tick per pre_div+1 clocks |
| top_wr | input | 1 | Write strobe for the period holding register |
| top_din | input | 16 | Period limit value |
| cmp_wr | input | 1 | Write strobe for the threshold holding register |
| cmp_din | input | 16 | Compare threshold value |
| invert | input | 1 | 1 selects the complemented waveform |
| pwm_out | output | 1 | PWM waveform |
| wrap_pulse | output | 1 | One-clock strobe after each restart of the period |

## Verification
The waveform is tried with a mid-range threshold at several divider settings. Each of the two polarities is run in turn, and the checks separate a correct count-to-level mapping from an output that is off by one count or that lags by the wrong number of clocks. The extreme thresholds are each set in turn: zero, equal to the limit, above the limit, and zero with a zero limit. These runs show whether the constant-output rules win over the plain comparison, and in the right order. Holding-register writes arrive at random times, including on the wrap clock, which catches any update made mid-period or any write taken one period early. Timed measurements of the period and of the high time confirm the frequency and duty formulas over whole periods.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;

  // Normal-polarity level for a count value: zero threshold wins, then
  // threshold at/above limit, then the plain comparison.
  function automatic logic level_at(input logic [31:0] cnt,
                                    input logic [31:0] cmp,
                                    input logic [31:0] lim);
    if (cmp == 32'd0) return 1'b1;
    if (cmp >= lim)   return 1'b0;
    return (cnt >= cmp);
  endfunction

  // Divider reached its setting (or was left above a smaller new one).
  function automatic logic tick_due(input logic [31:0] pre_cnt,
                                    input logic [31:0] div);
    return (pre_cnt >= div);
  endfunction

  // Timebase reached its limit and must restart.
  function automatic logic at_limit(input logic [31:0] cnt,
                                    input logic [31:0] lim);
    return (cnt >= lim);
  endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  import pwm_edge_pkg::*;

  logic [PRE_W-1:0] pre_q;

  assign tick = en && tick_due(32'(pre_q), 32'(div));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (en) begin
      if (tick) pre_q <= '0;
      else      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             top_wr,
  input  logic [CNT_W-1:0] top_din,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_din,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] top_act,
  output logic [CNT_W-1:0] cmp_act,
  output logic             wrap_ev
);
  import pwm_edge_pkg::*;

  logic [CNT_W-1:0] top_buf, cmp_buf;

  assign wrap_ev = tick && at_limit(32'(cnt), 32'(top_act));

  // holding stage: written any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_buf <= '0;
      cmp_buf <= '0;
    end else begin
      if (top_wr) top_buf <= top_din;
      if (cmp_wr) cmp_buf <= cmp_din;
    end
  end

  // working stage: copied only at the wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_act <= '0;
      cmp_act <= '0;
    end else if (wrap_ev) begin
      top_act <= top_buf;
      cmp_act <= cmp_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (wrap_ev) cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             invert,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] top_act,
  input  logic [CNT_W-1:0] cmp_act,
  input  logic             wrap_ev,
  output logic             lvl,
  output logic             pwm_out,
  output logic             wrap_pulse
);
  import pwm_edge_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl        <= 1'b0;
      wrap_pulse <= 1'b0;
    end else begin
      wrap_pulse <= en && wrap_ev;
      if (en) lvl <= level_at(32'(cnt), 32'(cmp_act), 32'(top_act));
    end
  end

  assign pwm_out = lvl ^ invert;
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] pre_div,
  input  logic             top_wr,
  input  logic [CNT_W-1:0] top_din,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_din,
  input  logic             invert,
  output logic             pwm_out,
  output logic             wrap_pulse
);
  logic             tick;
  logic             wrap_ev;
  logic             lvl;
  logic [CNT_W-1:0] cnt, top_act, cmp_act;

  pwm_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .div(pre_div), .tick(tick)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .top_wr(top_wr), .top_din(top_din),
    .cmp_wr(cmp_wr), .cmp_din(cmp_din),
    .cnt(cnt), .top_act(top_act), .cmp_act(cmp_act), .wrap_ev(wrap_ev)
  );

  pwm_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .en(en), .invert(invert),
    .cnt(cnt), .top_act(top_act), .cmp_act(cmp_act), .wrap_ev(wrap_ev),
    .lvl(lvl), .pwm_out(pwm_out), .wrap_pulse(wrap_pulse)
  );
endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             tick,
  input logic             wrap_ev,
  input logic             wrap_pulse,
  input logic             lvl,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] top_act,
  input logic [CNT_W-1:0] cmp_act
);
  // R2
  tick_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en);

  // R2
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt) && $stable(lvl) && !wrap_pulse));

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= top_act);

  // R3
  wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (cnt == '0) && wrap_pulse);

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_ev |=> ($stable(top_act) && $stable(cmp_act)));

  // R8
  high_cmp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmp_act != '0 && cmp_act >= top_act) |=> !lvl);

  // R9
  zero_cmp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmp_act == '0) |=> lvl);
endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .wrap_ev(wrap_ev),
  .wrap_pulse(wrap_pulse), .lvl(lvl), .cnt(cnt),
  .top_act(top_act), .cmp_act(cmp_act)
);

// File: tb/pwm_edge_gen_test.sv
`timescale 1ns/1ps
module pwm_edge_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [7:0]  pre_div = 8'd0;
  logic        top_wr = 1'b0, cmp_wr = 1'b0;
  logic [15:0] top_din = 16'd0, cmp_din = 16'd0;
  logic        invert = 1'b0;
  logic        pwm_out, wrap_pulse;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit rnd_wr = 1'b0;

  always #4 clk = ~clk;

  pwm_edge_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .pre_div(pre_div),
    .top_wr(top_wr), .top_din(top_din), .cmp_wr(cmp_wr), .cmp_din(cmp_din),
    .invert(invert), .pwm_out(pwm_out), .wrap_pulse(wrap_pulse)
  );

  // behavioural reference
  int m_pre, m_cnt, m_top, m_cmp, m_tbuf, m_cbuf;
  bit m_lvl, m_wp;

  function automatic bit ref_high(int c, int thr, int lim);
    bit below_lim = (thr < lim);
    if (thr == 0) return 1'b1;
    return below_lim && (c >= thr);
  endfunction

  always @(posedge clk) begin
    bit tk, wr;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_top = 0; m_cmp = 0;
      m_tbuf = 0; m_cbuf = 0; m_lvl = 0; m_wp = 0;
    end else begin
      if (en) begin
        m_lvl = ref_high(m_cnt, m_cmp, m_top);
        tk = (m_pre >= int'(pre_div));
        m_pre = tk ? 0 : m_pre + 1;
        wr = tk && (m_cnt >= m_top);
        m_wp = wr;
        if (tk) m_cnt = wr ? 0 : m_cnt + 1;
        if (wr) begin m_top = m_tbuf; m_cmp = m_cbuf; end
      end else begin
        m_wp = 0;
      end
      if (top_wr) m_tbuf = int'(top_din);
      if (cmp_wr) m_cbuf = int'(cmp_din);
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // per-clock comparison at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R5 R6 R8 R9 pwm_out", int'(pwm_out), int'(m_lvl ^ invert));
      check("R2 R3 wrap_pulse", int'(wrap_pulse), int'(m_wp));
    end
    if (rnd_wr) begin
      top_wr = ($urandom_range(0, 9) == 0);
      top_din = 16'($urandom_range(0, 12));
      cmp_wr = ($urandom_range(0, 9) == 0);
      cmp_din = 16'($urandom_range(0, 14));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_regs(int lim, int thr);
    @(negedge clk);
    top_wr = 1; top_din = 16'(lim); cmp_wr = 1; cmp_din = 16'(thr);
    @(negedge clk);
    top_wr = 0; cmp_wr = 0;
  endtask

  // measure one full period: clocks between pulses and high clocks
  task automatic measure(output int per, output int hi);
    per = 0; hi = 0;
    while (wrap_pulse !== 1'b1) @(negedge clk);
    @(negedge clk);
    do begin
      per++;
      if (pwm_out) hi++;
      @(negedge clk);
    end while (wrap_pulse !== 1'b1);
    per++;
    if (pwm_out) hi++;
  endtask

  initial begin
    int per, hi;
    idle(3);
    // R1: reset state
    check("R1 pwm_out in reset", int'(pwm_out), 0);
    check("R1 wrap_pulse in reset", int'(wrap_pulse), 0);
    invert = 1; #1;
    check("R1 idle level inverted", int'(pwm_out), 1);
    invert = 0;
    @(negedge clk); rst_n = 1;
    idle(4);
    check("R1 idle after reset, disabled", int'(pwm_out), 0);
    check("R2 no wrap while disabled", int'(wrap_pulse), 0);

    // main waveform
    set_regs(9, 3);
    en = 1;
    idle(40);
    measure(per, hi);
    check("R4 period pre_div=0", per, 10);
    check("R10 high time pre_div=0", hi, 7);
    pre_div = 2;
    idle(60);
    measure(per, hi);
    check("R4 period pre_div=2", per, 30);
    check("R10 high time pre_div=2", hi, 21);
    invert = 1;
    measure(per, hi);
    check("R6 inverted high time", hi, 9);
    invert = 0;

    // extremes
    set_regs(9, 0);  idle(70);
    measure(per, hi); check("R9 zero threshold stays high", hi, per);
    set_regs(9, 9);  idle(70);
    measure(per, hi); check("R8 threshold at limit stays low", hi, 0);
    set_regs(9, 12); idle(70);
    measure(per, hi); check("R8 threshold above limit stays low", hi, 0);
    pre_div = 0;
    set_regs(0, 0);  idle(20);
    check("R9 zero limit, zero threshold", int'(pwm_out), 1);

    // R7: new values wait for the wrap
    set_regs(7, 2); idle(30);
    measure(per, hi);
    check("R7 new limit after wrap", per, 8);
    check("R7 new threshold after wrap", hi, 6);

    // R2: freeze
    en = 0; idle(20);
    en = 1; idle(20);

    // random writes, compared each clock against the reference
    pre_div = 1;
    rnd_wr = 1; idle(3000);
    pre_div = 0; idle(3000);
    rnd_wr = 0; top_wr = 0; cmp_wr = 0;
    idle(5);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule